// File: doc/BRIEF.md
# Receive Pair Polarity Detector

This block decides whether the twisted-pair receive lines of a 10 Mb/s port are wired with their two conductors swapped. It never looks at analog waveforms or at data bits. Upstream logic classifies two kinds of events and hands them over as single-cycle strobes, each with a polarity bit: a received link pulse, and the idle level that follows the end-of-frame sequence of a received packet.

A reversal is declared only when both kinds of evidence agree. At least one inverted link pulse must have arrived since reset or the last link failure. A run of consecutive frames must also have ended with inverted polarity. Once declared, the reversal is withdrawn only after a run of consecutive normally ended frames, a link failure or a reset.

The block reports the reversal on a status flag. When the auto-correct bit is set, it also drives an invert control to the receive data path. That control only changes while no frame is in progress, so a packet is never split between two polarities.

Top module: `rxpol_detect`

## Requirements
- R1: After a synchronous reset, `reversed_o` and `invert_o` are both 0.
- R2: `reversed_o` becomes 1 when two conditions both hold: at least one link pulse with `lp_neg`=1 has been strobed, and the most recent NEG_RUN (default 4) end-of-frame strobes all carried `eof_neg`=1. The two kinds of evidence may arrive in either order. `reversed_o` rises on the second rising clock edge after the strobe that completes the evidence.
- R3: Inverted end-of-frame polarity alone, with no inverted link pulse, never sets `reversed_o`. Inverted link pulses alone, with fewer than NEG_RUN consecutive inverted frames, never set it either. A link pulse with `lp_neg`=0 adds no evidence.
- R4: An end-of-frame strobe with `eof_neg`=0 restarts the count of consecutive inverted frames from zero.
- R5: While `reversed_o`=1, it returns to 0 after POS_RUN (default 4) consecutive end-of-frame strobes with `eof_neg`=0. Any inverted frame restarts that count, and fewer than POS_RUN normal frames leave the flag set.
- R6: A cycle with `link_fail`=1 clears `reversed_o`, both frame counts and the inverted-pulse evidence. After it, inverted frames without a new inverted link pulse do not set `reversed_o`.
- R7: When `frame_busy`=0, `invert_o` follows `reversed_o` AND `auto_fix_en` one clock edge later. With `auto_fix_en`=0 the reversal is only reported and `invert_o` stays 0.
- R8: While `frame_busy`=1, `invert_o` holds its value. It changes on the first clock edge that samples `frame_busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_stb | input | 1 | One-cycle strobe: a link pulse was received |
| lp_neg | input | 1 | Polarity of that link pulse, 1 = inverted |
| eof_stb | input | 1 | One-cycle strobe: a frame end was received |
| eof_neg | input | 1 | Polarity after that frame end, 1 = inverted |
| frame_busy | input | 1 | 1 while a frame is being received |
| link_fail | input | 1 | 1 when the link has failed |
| auto_fix_en | input | 1 | Configuration bit: enable automatic correction |
| reversed_o | output | 1 | Registered reversed-pair status |
| invert_o | output | 1 | Registered invert control to the receive data path |

## Verification
The bench builds the block with its default run lengths, NEG_RUN = 4 and POS_RUN = 4. With these values, sequences that stop one frame short of either threshold are short enough to be reached often by directed cases and by random streams of events. The random streams mix link pulses of both polarities, frame ends, occasional link failures and changes of the auto-correct bit. Many of them break a run at 3 frames, or interleave the pulse evidence before and after the frame run. A directed case keeps `frame_busy` high across a declaration to show that the invert control holds until the frame gap.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;
  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic {
    RUN_NEG = 1'b0,
    RUN_POS = 1'b1
  } run_kind_e;
endpackage

// File: rtl/rxpol_evidence_flag.sv
module rxpol_evidence_flag (
  input  logic clk,
  input  logic rst,
  input  logic lp_stb,
  input  logic lp_neg,
  input  logic link_fail,
  output logic seen_o
);
  always_ff @(posedge clk) begin
    if (rst || link_fail) seen_o <= 1'b0;
    else if (lp_stb && lp_neg) seen_o <= 1'b1;
  end

  // R6
  evidence_drop_chk: assert property (@(posedge clk) disable iff (rst)
    link_fail |=> !seen_o);
endmodule

// File: rtl/rxpol_run_cnt.sv
module rxpol_run_cnt #(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned CW    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic stb,
  input  logic match,
  output logic full_o
);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (stb) begin
      if (!match) cnt <= '0;
      else if (cnt != TOP) cnt <= cnt + 1'b1;
    end
  end

  assign full_o = (cnt == TOP);

  // R4
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);
  // R4
  run_break_chk: assert property (@(posedge clk) disable iff (rst)
    (stb && !match) |=> (cnt == '0));
endmodule

// File: rtl/rxpol_decide.sv
module rxpol_decide (
  input  logic clk,
  input  logic rst,
  input  logic link_fail,
  input  logic seen,
  input  logic neg_full,
  input  logic pos_full,
  input  logic frame_busy,
  input  logic auto_fix_en,
  output logic reversed_o,
  output logic invert_o
);
  always_ff @(posedge clk) begin
    if (rst || link_fail) reversed_o <= 1'b0;
    else if (!reversed_o && seen && neg_full) reversed_o <= 1'b1;
    else if (reversed_o && pos_full) reversed_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) invert_o <= 1'b0;
    else if (!frame_busy) invert_o <= reversed_o && auto_fix_en;
  end

  // R2
  declare_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reversed_o) |-> ($past(seen) && $past(neg_full)));
  // R6
  fail_clear_chk: assert property (@(posedge clk) disable iff (rst)
    link_fail |=> !reversed_o);
  // R8
  gap_only_chk: assert property (@(posedge clk) disable iff (rst)
    frame_busy |=> $stable(invert_o));
  // R7
  manual_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!frame_busy && !auto_fix_en) |=> !invert_o);
endmodule

// File: rtl/rxpol_detect.sv
module rxpol_detect #(
  parameter int unsigned NEG_RUN = 4,
  parameter int unsigned POS_RUN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lp_stb,
  input  logic lp_neg,
  input  logic eof_stb,
  input  logic eof_neg,
  input  logic frame_busy,
  input  logic link_fail,
  input  logic auto_fix_en,
  output logic reversed_o,
  output logic invert_o
);
  import rxpol_pkg::*;

  localparam int unsigned CW = $clog2(max2(NEG_RUN, POS_RUN) + 1);

  logic       seen;
  logic [1:0] full;

  rxpol_evidence_flag u_flag (
    .clk(clk), .rst(rst), .lp_stb(lp_stb), .lp_neg(lp_neg),
    .link_fail(link_fail), .seen_o(seen)
  );

  for (genvar k = 0; k < 2; k++) begin : g_run
    localparam int unsigned LIM = (k == int'(RUN_NEG)) ? NEG_RUN : POS_RUN;
    logic want;
    assign want = (k == int'(RUN_NEG)) ? eof_neg : !eof_neg;
    rxpol_run_cnt #(.LIMIT(LIM), .CW(CW)) u_run (
      .clk(clk), .rst(rst), .clr(link_fail), .stb(eof_stb),
      .match(want), .full_o(full[k])
    );
  end

  rxpol_decide u_dec (
    .clk(clk), .rst(rst), .link_fail(link_fail), .seen(seen),
    .neg_full(full[RUN_NEG]), .pos_full(full[RUN_POS]),
    .frame_busy(frame_busy), .auto_fix_en(auto_fix_en),
    .reversed_o(reversed_o), .invert_o(invert_o)
  );
endmodule

// File: tb/rxpol_detect_test.sv
`timescale 1ns/1ps
module rxpol_detect_test;
  localparam int NRUN = 4;
  localparam int PRUN = 4;

  logic clk = 1'b0;
  logic rst, lp_stb, lp_neg, eof_stb, eof_neg, frame_busy, link_fail, auto_fix_en;
  logic reversed_o, invert_o;

  always #2.5 clk = ~clk;

  rxpol_detect #(.NEG_RUN(NRUN), .POS_RUN(PRUN)) uut (
    .clk(clk), .rst(rst), .lp_stb(lp_stb), .lp_neg(lp_neg),
    .eof_stb(eof_stb), .eof_neg(eof_neg), .frame_busy(frame_busy),
    .link_fail(link_fail), .auto_fix_en(auto_fix_en),
    .reversed_o(reversed_o), .invert_o(invert_o)
  );

  int checks = 0;
  int fails = 0;
  bit m_seen, m_rev;
  int m_nc, m_pc;

  function automatic bit exp_inv();
    return m_rev && auto_fix_en;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_seen = 0; m_rev = 0; m_nc = 0; m_pc = 0;
  endtask

  // kind: 0 link pulse, 1 frame end, 2 link failure
  function automatic void model_ev(input int kind, input bit neg);
    if (kind == 0) begin
      if (neg) m_seen = 1;
    end else if (kind == 1) begin
      if (neg) begin m_nc = (m_nc < NRUN) ? m_nc + 1 : NRUN; m_pc = 0; end
      else begin m_pc = (m_pc < PRUN) ? m_pc + 1 : PRUN; m_nc = 0; end
    end else begin
      m_seen = 0; m_rev = 0; m_nc = 0; m_pc = 0;
    end
    if (!m_rev && m_seen && m_nc >= NRUN) m_rev = 1;
    else if (m_rev && m_pc >= PRUN) m_rev = 0;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ev(input int kind, input bit neg);
    @(negedge clk);
    lp_stb = (kind == 0); lp_neg = neg;
    eof_stb = (kind == 1); eof_neg = neg;
    link_fail = (kind == 2);
    @(negedge clk);
    lp_stb = 0; eof_stb = 0; link_fail = 0; lp_neg = 0; eof_neg = 0;
    idle(2);
    model_ev(kind, neg);
  endtask

  task automatic ev_chk(input string req, input int kind, input bit neg);
    ev(kind, neg);
    chk(req, reversed_o, m_rev);
    chk(req, invert_o, exp_inv());
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; idle(2); rst = 0; model_reset();
  endtask

  initial begin
    #900000;
    fails++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1; lp_stb = 0; lp_neg = 0; eof_stb = 0; eof_neg = 0;
    frame_busy = 0; link_fail = 0; auto_fix_en = 1;
    idle(3);
    // R1
    chk("R1", reversed_o, 1'b0); chk("R1", invert_o, 1'b0);
    rst = 0; model_reset(); idle(1);

    // R2: pulse first, then frames; latency at 2nd edge after strobe
    ev_chk("R2", 0, 1);
    for (int i = 0; i < NRUN - 1; i++) ev_chk("R2", 1, 1);
    @(negedge clk); eof_stb = 1; eof_neg = 1;
    @(negedge clk); eof_stb = 0; eof_neg = 0;
    chk("R2", reversed_o, 1'b0);
    @(negedge clk); chk("R2", reversed_o, 1'b1);
    @(negedge clk); chk("R7", invert_o, 1'b1);
    model_ev(1, 1);

    // R5: three normal frames keep it, fourth clears
    for (int i = 0; i < PRUN - 1; i++) ev_chk("R5", 1, 0);
    chk("R5", reversed_o, 1'b1);
    ev_chk("R5", 1, 1);
    for (int i = 0; i < PRUN - 1; i++) ev_chk("R5", 1, 0);
    chk("R5", reversed_o, 1'b1);
    ev_chk("R5", 1, 0);
    chk("R5", reversed_o, 1'b0);

    // R3: frames only
    do_reset();
    for (int i = 0; i < NRUN + 2; i++) ev_chk("R3", 1, 1);
    ev_chk("R3", 0, 0);
    chk("R3", reversed_o, 1'b0);
    ev_chk("R2", 0, 1); // pulse after frames
    chk("R2", reversed_o, 1'b1);

    // R4: broken run
    do_reset();
    ev_chk("R4", 0, 1);
    for (int i = 0; i < NRUN - 1; i++) ev_chk("R4", 1, 1);
    ev_chk("R4", 1, 0);
    for (int i = 0; i < NRUN - 1; i++) ev_chk("R4", 1, 1);
    chk("R4", reversed_o, 1'b0);
    ev_chk("R4", 1, 1);
    chk("R4", reversed_o, 1'b1);

    // R6: link failure wipes status and pulse evidence
    ev_chk("R6", 2, 0);
    chk("R6", reversed_o, 1'b0);
    for (int i = 0; i < NRUN + 1; i++) ev_chk("R6", 1, 1);
    chk("R6", reversed_o, 1'b0);

    // R7: report only
    do_reset();
    auto_fix_en = 0;
    ev_chk("R7", 0, 1);
    for (int i = 0; i < NRUN; i++) ev_chk("R7", 1, 1);
    chk("R7", reversed_o, 1'b1); chk("R7", invert_o, 1'b0);
    @(negedge clk); auto_fix_en = 1;
    @(negedge clk); chk("R7", invert_o, 1'b1);

    // R8: hold while frame in progress
    do_reset();
    ev_chk("R8", 0, 1);
    for (int i = 0; i < NRUN - 1; i++) ev_chk("R8", 1, 1);
    frame_busy = 1;
    ev(1, 1);
    idle(4);
    chk("R8", reversed_o, 1'b1); chk("R8", invert_o, 1'b0);
    frame_busy = 0;
    @(negedge clk); chk("R8", invert_o, 1'b1);

    // random mix
    do_reset();
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(99);
      bit pol = $urandom_range(1);
      if (r < 3) begin
        @(negedge clk); auto_fix_en = ~auto_fix_en; idle(1);
      end
      if (r < 5) ev_chk("R6", 2, 0);
      else if (r < 25) ev_chk("R3", 0, pol);
      else ev_chk("R4", 1, (r < 65) ? 1'b1 : pol);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule